// File: doc/BRIEF.md
# VLAN-Aware Egress Port Mask Filter

This block decides, for each frame that enters a five-port switch, which egress ports it may be forwarded to. A request carries the ingress port number, whether the frame arrived with a VLAN tag, and the VLAN ID decoded from that tag. The block resolves the frame's VLAN (the tag's ID, or the ingress port's default ID when the frame is untagged), looks it up in a small VLAN membership table, and intersects the VLAN's member set with the ingress port's isolation domain. The ingress port is always removed from the result. The resulting mask and a drop flag are returned two cycles after the request.

VLAN awareness is one switch-wide setting. When it is on, a frame whose VLAN is unknown, or whose VLAN does not list the ingress port as a member, is dropped at ingress. When it is off, VLAN membership plays no part and only the isolation domain limits the egress set. All configuration (default VLAN per port, isolation domain per port, table entries, the global awareness bit) is loaded through a single-cycle register write port.

Top module: `vfm_top`

## Requirements
- R1: After reset: rsp_valid, rsp_mask and rsp_drop are 0, VLAN awareness is off, every port's default VLAN ID is 1, every port's isolation domain holds all ports, and no table entry is valid.
- R2: A request sampled on edge E produces rsp_valid on edge E+2; a new request may be accepted on every cycle.
- R3: An untagged request (req_tagged=0) uses the ingress port's default VLAN ID; a tagged request uses req_vid.
- R4: With VLAN awareness on and the frame accepted, rsp_mask is the ingress port's isolation domain ANDed with the VLAN's member set, with bit i meaning port i.
- R5: With VLAN awareness on, a frame is dropped when its VLAN ID matches no valid entry or when the matching entry's member set does not include the ingress port.
- R6: With VLAN awareness off, VLAN membership is ignored: rsp_mask is the ingress port's isolation domain, even for VLAN IDs absent from the table.
- R7: The ingress port's own bit is always 0 in rsp_mask.
- R8: rsp_drop is 1 exactly when a response carries an all-zero rsp_mask; when rsp_valid is 0 both outputs are 0.
- R9: A request whose req_port is 5 or above is dropped.
- R10: When several valid entries hold the same VLAN ID, the entry with the lowest index supplies the member set.
- R11: A configuration write is seen by any request sampled on the same edge as the write's following cycle or later.
- R12: Write encoding: cfg_sel 0 loads the default VLAN ID of port cfg_idx from cfg_data[11:0]; 1 loads the isolation domain of port cfg_idx from cfg_data[4:0]; 2 loads table entry cfg_idx with VLAN ID cfg_data[11:0], members cfg_data[16:12], valid cfg_data[17]; 3 loads VLAN awareness from cfg_data[0]. Port writes with cfg_idx of 5 or above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target of the write (see R12) |
| cfg_idx | input | 4 | Port number or table entry index |
| cfg_data | input | 18 | Write data |
| req_valid | input | 1 | Lookup request strobe |
| req_port | input | 3 | Ingress port number |
| req_tagged | input | 1 | Frame carried a VLAN tag |
| req_vid | input | 12 | VLAN ID decoded from the tag |
| rsp_valid | output | 1 | Result strobe, two cycles after the request |
| rsp_mask | output | 5 | Permitted egress ports |
| rsp_drop | output | 1 | Frame is discarded |

## Verification
A wrong table entry or a stale default VLAN ID shows up as a wrong rsp_mask or a spurious drop on the second cycle after the first request that resolves to the damaged VLAN or port, and is invisible until such a request arrives; vectors therefore cover every configured VLAN and port. A bad priority in the table shows only when two entries share an ID, so one duplicated ID is loaded on purpose. A wrong awareness bit flips whole classes of frames between dropped and forwarded, which the awareness-off tests expose at once.

// File: rtl/vfm_pkg.sv
// Shared types for the VLAN-aware egress mask filter.
// Assumes: configuration targets are a two-bit code, fixed by R12.
package vfm_pkg;

    typedef enum logic [1:0] {
        SEL_PORT_VID  = 2'd0,
        SEL_DOMAIN    = 2'd1,
        SEL_VLAN_ENT  = 2'd2,
        SEL_AWARENESS = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/vfm_port_cfg.sv
// Per-port default VLAN IDs, per-port isolation domains and the global
// VLAN awareness bit; returns the settings of one selected port.
// Assumes: writes to port numbers at or above NUM_PORTS are ignored,
// and a read of such a port returns zeros.
module vfm_port_cfg
    import vfm_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int VID_W     = 12,
    parameter int IDX_W     = 4,
    parameter int CFG_W     = 18,
    parameter int PIDX_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [CFG_W-1:0]     wr_data,
    input  logic [PIDX_W-1:0]    rd_port,
    output logic [VID_W-1:0]     rd_pvid,
    output logic [NUM_PORTS-1:0] rd_domain,
    output logic                 aware_en
);

    logic [VID_W-1:0]     pvid_q   [NUM_PORTS];
    logic [NUM_PORTS-1:0] domain_q [NUM_PORTS];
    logic                 aware_q;
    logic                 idx_ok;

    assign idx_ok = int'(wr_idx) < NUM_PORTS;

    // Per-port register file, one generate slice per port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pvid_q[p]   <= VID_W'(1);
                domain_q[p] <= '1;
            end else if (wr_en && idx_ok && int'(wr_idx) == p) begin
                if (wr_sel == SEL_PORT_VID)
                    pvid_q[p] <= wr_data[VID_W-1:0];
                if (wr_sel == SEL_DOMAIN)
                    domain_q[p] <= wr_data[NUM_PORTS-1:0];
            end
        end
    end

    // Global VLAN awareness bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            aware_q <= 1'b0;
        else if (wr_en && wr_sel == SEL_AWARENESS)
            aware_q <= wr_data[0];
    end

    // Read mux for the port under lookup.
    always_comb begin
        rd_pvid   = '0;
        rd_domain = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (int'(rd_port) == p) begin
                rd_pvid   = pvid_q[p];
                rd_domain = domain_q[p];
            end
        end
    end

    assign aware_en = aware_q;

endmodule

// File: rtl/vfm_vlan_table.sv
// VLAN membership table: ENTRIES slots of {valid, members, VLAN ID}
// searched in parallel; the lowest matching index wins.
// Assumes: a write and a lookup in the same cycle see the old contents.
module vfm_vlan_table
    import vfm_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int ENTRIES   = 16,
    parameter int VID_W     = 12,
    parameter int IDX_W     = 4,
    parameter int CFG_W     = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [CFG_W-1:0]     wr_data,
    input  logic [VID_W-1:0]     key_vid,
    output logic                 hit,
    output logic [NUM_PORTS-1:0] members
);

    localparam int VLD_BIT = VID_W + NUM_PORTS;

    logic [VID_W-1:0]     ent_vid [ENTRIES];
    logic [NUM_PORTS-1:0] ent_mem [ENTRIES];
    logic [ENTRIES-1:0]   ent_vld;
    logic [ENTRIES-1:0]   match;

    // Entry storage and match compare, one slice per entry.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_vld[e] <= 1'b0;
                ent_vid[e] <= '0;
                ent_mem[e] <= '0;
            end else if (wr_en && wr_sel == SEL_VLAN_ENT && int'(wr_idx) == e) begin
                ent_vld[e] <= wr_data[VLD_BIT];
                ent_mem[e] <= wr_data[VID_W +: NUM_PORTS];
                ent_vid[e] <= wr_data[VID_W-1:0];
            end
        end
        assign match[e] = ent_vld[e] && (ent_vid[e] == key_vid);
    end

    // Priority select: scan downward so the lowest index is kept last.
    always_comb begin
        hit     = 1'b0;
        members = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (match[e]) begin
                hit     = 1'b1;
                members = ent_mem[e];
            end
        end
    end

    // A valid entry just written must be found by a lookup of its ID.
    assert_wr_visible_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_VLAN_ENT && int'(wr_idx) < ENTRIES && wr_data[VLD_BIT])
        |=> ((key_vid != $past(wr_data[VID_W-1:0])) || hit));

endmodule

// File: rtl/vfm_mask_combine.sv
// Forms the egress mask: isolation domain AND VLAN set, source removed,
// with ingress filtering when awareness is on and drop on an empty mask.
// Assumes: members is zero whenever hit is zero.
module vfm_mask_combine #(
    parameter int NUM_PORTS = 5,
    parameter int PIDX_W    = 3
) (
    input  logic [PIDX_W-1:0]    src_port,
    input  logic [NUM_PORTS-1:0] domain,
    input  logic                 aware_en,
    input  logic                 hit,
    input  logic [NUM_PORTS-1:0] members,
    output logic [NUM_PORTS-1:0] egress,
    output logic                 drop,
    output logic                 rejected
);

    logic                 port_ok;
    logic [NUM_PORTS-1:0] src_bit;
    logic [NUM_PORTS-1:0] vlan_set;

    assign port_ok = int'(src_port) < NUM_PORTS;

    // One-hot of the ingress port (zero when out of range).
    always_comb begin
        src_bit = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (int'(src_port) == p) src_bit[p] = 1'b1;
    end

    // Ingress filter decision and mask intersection.
    always_comb begin
        vlan_set = aware_en ? members : '1;
        rejected = !port_ok || (aware_en && !(hit && |(members & src_bit)));
        egress   = rejected ? '0 : (domain & vlan_set & ~src_bit);
        drop     = (egress == '0);
    end

endmodule

// File: rtl/vfm_top.sv
// VLAN-aware egress mask filter: two-stage pipeline. Stage 1 registers
// the request; the lookup and mask logic then feeds the output register.
// Assumes: one request per cycle at most; configuration through the
// write port only.
module vfm_top #(
    parameter int NUM_PORTS    = 5,
    parameter int VLAN_ENTRIES = 16,
    parameter int VID_W        = 12,
    localparam int PIDX_W      = $clog2(NUM_PORTS),
    localparam int TIDX_W      = $clog2(VLAN_ENTRIES),
    localparam int IDX_W       = (TIDX_W > PIDX_W) ? TIDX_W : PIDX_W,
    localparam int CFG_W       = VID_W + NUM_PORTS + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [CFG_W-1:0]     cfg_data,
    input  logic                 req_valid,
    input  logic [PIDX_W-1:0]    req_port,
    input  logic                 req_tagged,
    input  logic [VID_W-1:0]     req_vid,
    output logic                 rsp_valid,
    output logic [NUM_PORTS-1:0] rsp_mask,
    output logic                 rsp_drop
);

    logic                 s1_valid;
    logic [PIDX_W-1:0]    s1_port;
    logic                 s1_tagged;
    logic [VID_W-1:0]     s1_vid;

    logic [VID_W-1:0]     port_pvid;
    logic [NUM_PORTS-1:0] port_domain;
    logic                 aware_en;
    logic [VID_W-1:0]     eff_vid;
    logic                 tbl_hit;
    logic [NUM_PORTS-1:0] tbl_members;
    logic [NUM_PORTS-1:0] egress;
    logic                 drop;
    logic                 rejected;

    // Stage 1: capture the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_port   <= '0;
            s1_tagged <= 1'b0;
            s1_vid    <= '0;
        end else begin
            s1_valid  <= req_valid;
            s1_port   <= req_port;
            s1_tagged <= req_tagged;
            s1_vid    <= req_vid;
        end
    end

    vfm_port_cfg #(
        .NUM_PORTS(NUM_PORTS), .VID_W(VID_W), .IDX_W(IDX_W),
        .CFG_W(CFG_W), .PIDX_W(PIDX_W)
    ) u_port_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_idx(cfg_idx), .wr_data(cfg_data),
        .rd_port(s1_port), .rd_pvid(port_pvid), .rd_domain(port_domain),
        .aware_en(aware_en)
    );

    // VLAN resolution: tag ID or the port default.
    assign eff_vid = s1_tagged ? s1_vid : port_pvid;

    vfm_vlan_table #(
        .NUM_PORTS(NUM_PORTS), .ENTRIES(VLAN_ENTRIES), .VID_W(VID_W),
        .IDX_W(IDX_W), .CFG_W(CFG_W)
    ) u_vlan_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_idx(cfg_idx), .wr_data(cfg_data),
        .key_vid(eff_vid), .hit(tbl_hit), .members(tbl_members)
    );

    vfm_mask_combine #(
        .NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W)
    ) u_combine (
        .src_port(s1_port), .domain(port_domain), .aware_en(aware_en),
        .hit(tbl_hit), .members(tbl_members),
        .egress(egress), .drop(drop), .rejected(rejected)
    );

    // Stage 2: register the result; idle cycles show zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_mask  <= '0;
            rsp_drop  <= 1'b0;
        end else begin
            rsp_valid <= s1_valid;
            rsp_mask  <= s1_valid ? egress : '0;
            rsp_drop  <= s1_valid && drop;
        end
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ##2 rsp_valid);

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_mask == '0 && !rsp_drop));

    assert_drop_iff_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_drop == (rsp_mask == '0)));

    assert_src_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && int'(s1_port) < NUM_PORTS) |=> (rsp_mask[$past(s1_port)] == 1'b0));

    assert_within_domain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> ((rsp_mask & ~$past(port_domain)) == '0));

    assert_ingress_filter_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && aware_en && !tbl_hit) |=> rsp_drop);

    assert_bad_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && int'(s1_port) >= NUM_PORTS) |=> rsp_drop);

endmodule

// File: tb/test_vfm_top.sv
module test_vfm_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [3:0]  cfg_idx;
    logic [17:0] cfg_data;
    logic        req_valid;
    logic [2:0]  req_port;
    logic        req_tagged;
    logic [11:0] req_vid;
    logic        rsp_valid;
    logic [4:0]  rsp_mask;
    logic        rsp_drop;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    vfm_top i_vfm_top (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .req_valid(req_valid), .req_port(req_port), .req_tagged(req_tagged),
        .req_vid(req_vid),
        .rsp_valid(rsp_valid), .rsp_mask(rsp_mask), .rsp_drop(rsp_drop)
    );

    // Vector: {port[2:0], tagged, vid[11:0], exp_mask[4:0], exp_drop}
    localparam int NVEC = 12;
    localparam logic [21:0] VEC [NVEC] = '{
        {3'd0, 1'b0, 12'd10,  5'b00110, 1'b0},  // R3 R4 untagged p0 -> VID10
        {3'd1, 1'b1, 12'd100, 5'b01001, 1'b0},  // R10 lowest entry wins
        {3'd2, 1'b1, 12'd100, 5'b00000, 1'b1},  // R5 not a member
        {3'd2, 1'b0, 12'd0,   5'b01000, 1'b0},  // R3 untagged p2 -> VID20
        {3'd3, 1'b0, 12'd0,   5'b00100, 1'b0},  // R7 own bit removed
        {3'd4, 1'b0, 12'd0,   5'b00000, 1'b1},  // R8 isolated port, empty
        {3'd0, 1'b1, 12'd30,  5'b00000, 1'b1},  // R4 domain AND members empty
        {3'd0, 1'b1, 12'd200, 5'b00000, 1'b1},  // R5 invalid entry
        {3'd0, 1'b1, 12'd999, 5'b00000, 1'b1},  // R5 unknown VID
        {3'd1, 1'b1, 12'd10,  5'b00101, 1'b0},  // R4 tagged VID10
        {3'd5, 1'b1, 12'd10,  5'b00000, 1'b1},  // R9 port out of range
        {3'd3, 1'b1, 12'd100, 5'b00011, 1'b0}   // R4 tagged member p3
    };

    task automatic check(input string req, input logic [4:0] am, input logic ad,
                         input logic [4:0] em, input logic ed);
        checks++;
        if (am !== em || ad !== ed) begin
            failures++;
            $display("FAIL %s mask=%b drop=%b expected mask=%b drop=%b", req, am, ad, em, ed);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [3:0] idx, input logic [17:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [17:0] vlan_ent(input logic vld, input logic [4:0] mem,
                                             input logic [11:0] vid);
        return {vld, mem, vid};
    endfunction

    // Issue one request and check the response two edges later.
    task automatic lookup(input string req, input logic [2:0] port, input logic tg,
                          input logic [11:0] vid, input logic [4:0] em, input logic ed);
        @(negedge clk);
        req_valid = 1'b1; req_port = port; req_tagged = tg; req_vid = vid;
        @(negedge clk);
        req_valid = 1'b0;
        checks++;
        if (rsp_valid !== 1'b0) begin
            failures++;
            $display("FAIL R2 early rsp_valid=%b expected 0", rsp_valid);
        end
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b1) begin
            failures++;
            $display("FAIL R2 rsp_valid=%b expected 1", rsp_valid);
        end
        check(req, rsp_mask, rsp_drop, em, ed);
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_idx = '0; cfg_data = '0;
        req_valid = 1'b0; req_port = '0; req_tagged = 1'b0; req_vid = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset outputs
        checks++;
        if (rsp_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 rsp_valid=%b expected 0", rsp_valid);
        end
        check("R1 reset outputs", rsp_mask, rsp_drop, 5'b00000, 1'b0);
        // R1 awareness off, all ports in every domain
        lookup("R1 reset domain", 3'd2, 1'b1, 12'd77, 5'b11011, 1'b0);
        // R1 empty table: awareness on drops everything
        cfg_write(2'd3, 4'd0, 18'd1);
        lookup("R1 empty table", 3'd0, 1'b0, 12'd0, 5'b00000, 1'b1);
        // R1 default VID is 1; R11 write seen next cycle
        cfg_write(2'd2, 4'd0, vlan_ent(1'b1, 5'b11111, 12'd1));
        lookup("R1 default VID 1", 3'd0, 1'b0, 12'd0, 5'b11110, 1'b0);

        // R12 configuration load
        cfg_write(2'd0, 4'd0, 18'd10);
        cfg_write(2'd0, 4'd1, 18'd10);
        cfg_write(2'd0, 4'd2, 18'd20);
        cfg_write(2'd0, 4'd3, 18'd20);
        cfg_write(2'd0, 4'd4, 18'd30);
        for (int p = 0; p < 4; p++) cfg_write(2'd1, 4'(p), 18'b01111);
        cfg_write(2'd1, 4'd4, 18'b10000);
        cfg_write(2'd1, 4'd7, 18'b00000);      // R12 out-of-range port ignored
        cfg_write(2'd2, 4'd0, vlan_ent(1'b1, 5'b00111, 12'd10));
        cfg_write(2'd2, 4'd1, vlan_ent(1'b1, 5'b01100, 12'd20));
        cfg_write(2'd2, 4'd2, vlan_ent(1'b1, 5'b01011, 12'd100));
        cfg_write(2'd2, 4'd3, vlan_ent(1'b1, 5'b10001, 12'd30));
        cfg_write(2'd2, 4'd4, vlan_ent(1'b0, 5'b11111, 12'd200));
        cfg_write(2'd2, 4'd5, vlan_ent(1'b1, 5'b11111, 12'd100));

        for (int i = 0; i < NVEC; i++) begin
            lookup($sformatf("vector %0d", i), VEC[i][21:19], VEC[i][18], VEC[i][17:6],
                   VEC[i][5:1], VEC[i][0]);
        end

        // R11 change a table entry, next request sees it
        cfg_write(2'd2, 4'd0, vlan_ent(1'b1, 5'b11111, 12'd10));
        lookup("R11 entry rewrite", 3'd0, 1'b0, 12'd0, 5'b01110, 1'b0);
        // R3 R11 new default VID for p0 (VID20, p0 not a member)
        cfg_write(2'd0, 4'd0, 18'd20);
        lookup("R3 new default VID", 3'd0, 1'b0, 12'd0, 5'b00000, 1'b1);

        // R6 awareness off: membership ignored
        cfg_write(2'd3, 4'd0, 18'd0);
        lookup("R6 non-member forwarded", 3'd2, 1'b1, 12'd100, 5'b01011, 1'b0);
        lookup("R6 unknown VID forwarded", 3'd1, 1'b1, 12'd999, 5'b01101, 1'b0);
        lookup("R6 R7 isolated port", 3'd4, 1'b0, 12'd0, 5'b00000, 1'b1);
        lookup("R9 bad port aware off", 3'd6, 1'b0, 12'd0, 5'b00000, 1'b1);

        // R2 back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_port = 3'd0; req_tagged = 1'b1; req_vid = 12'd5;
        @(negedge clk);
        req_port = 3'd3;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 pipelined first", rsp_mask, rsp_drop, 5'b01110, 1'b0);
        @(negedge clk);
        check("R2 pipelined second", rsp_mask, rsp_drop, 5'b00111, 1'b0);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            failures++;
            $display("FAIL R8 rsp_valid=%b expected 0", rsp_valid);
        end
        check("R8 idle outputs", rsp_mask, rsp_drop, 5'b00000, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule